// File: doc/BRIEF.md
# Programmable IO address window decoder

The block maps a 48-bit physical address to a target ID using a set of software-programmed windows. Each window has an inclusive start and end address with 1 MB granularity, an enable bit and a target ID. An address inside an enabled window returns that window's target and a hit flag. An address outside every enabled window returns a default target from a global register, and the hit flag is low. When windows overlap, the window with the lowest index takes precedence.

Software programs the windows through a plain 32-bit register port. A write completes in one clock, and read data is combinational on the offset. A separate lookup port takes an address with a valid strobe and returns the registered result one cycle later. Window 0 decodes like every other window. By convention it is left for boot firmware, so software starts its own windows at index 1.

Top module: `io_window_decoder`

## Requirements
- R1: For window w, the start register is at byte offset 16*w+0x0, the end register at 16*w+0x8 and the target register at 16*w+0xC. The default-target register is at offset 16*NUM_WIN.
- R2: Start register bits [31:4] hold address bits [47:20], bit 0 is the enable, and bits [3:1] read 0. End register bits [31:4] hold address bits [47:20], and bits [3:0] read 0. The target and default registers keep bits [7:0], and their upper bits read 0.
- R3: An enabled window matches an address when address bits [47:20] lie between its start and end fields, both bounds included. Address bits [19:0] have no effect on the result.
- R4: A window whose enable bit is 0 never matches. Its start field still reads back unchanged after the enable bit is cleared.
- R5: When no enabled window matches, lk_target equals the default register and lk_hit is 0.
- R6: The result appears on lk_hit and lk_target, with lk_out_valid high, on the clock after a cycle with lk_valid high. Lookups may be issued back to back. In a cycle with lk_valid low, lk_out_valid goes low and lk_hit and lk_target hold their values.
- R7: When several enabled windows match an address, the target of the lowest-numbered one is returned.
- R8: An offset that is not listed in R1 reads as 0, and a write to it changes no register and no lookup result.
- R9: After reset, all registers read 0, every window is disabled, and a lookup returns lk_hit 0 with target 0.
- R10: An enabled window whose end field is below its start field matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 48 | Lookup physical address |
| lk_out_valid | output | 1 | Lookup result valid, one cycle after the request |
| lk_hit | output | 1 | High when an enabled window matched |
| lk_target | output | 8 | Target ID of the winning window, or the default target |

## Verification
A corrupted window field, such as a stuck enable, a shifted bound or a wrong target, shows up in the register readback as soon as the offset is presented. It also shows up in the lookup result on the cycle after any address in the affected granule range. A fault in the priority chain only appears on overlapping windows, and a fault in the comparators only appears at granules next to a bound. For that reason the bench sweeps every granule in a small range around the window edges. It repeats the sweep after each change to enable bits and priorities. It also probes the top granule of the address space.

// File: rtl/iow_pkg.sv
package iow_pkg;

    localparam int unsigned IOW_ADDR_W   = 48;
    localparam int unsigned IOW_GRAN_LSB = 20;
    localparam int unsigned IOW_GRAN_W   = IOW_ADDR_W - IOW_GRAN_LSB;
    localparam int unsigned IOW_DATA_W   = 32;
    localparam int unsigned IOW_FIELD_LSB = IOW_DATA_W - IOW_GRAN_W;
    localparam int unsigned IOW_TGT_W    = 8;
    localparam int unsigned IOW_STRIDE_B = 4;   // log2 of the 16-byte window stride

    typedef logic [IOW_GRAN_W-1:0] gran_t;
    typedef logic [IOW_TGT_W-1:0]  tgt_t;
    typedef logic [IOW_DATA_W-1:0] word_t;

    typedef struct packed {
        logic  en;
        gran_t lo;
        gran_t hi;
        tgt_t  tgt;
    } win_cfg_t;

    typedef struct packed {
        logic hit;
        tgt_t tgt;
    } lookup_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_START,
        RK_END,
        RK_TGT,
        RK_DFLT
    } reg_kind_e;

    function automatic gran_t addr_gran(input logic [IOW_ADDR_W-1:0] a);
        return a[IOW_ADDR_W-1:IOW_GRAN_LSB];
    endfunction

    function automatic word_t start_image(input win_cfg_t c);
        word_t w;
        w = '0;
        w[IOW_DATA_W-1:IOW_FIELD_LSB] = c.lo;
        w[0] = c.en;
        return w;
    endfunction

    function automatic word_t end_image(input win_cfg_t c);
        word_t w;
        w = '0;
        w[IOW_DATA_W-1:IOW_FIELD_LSB] = c.hi;
        return w;
    endfunction

    function automatic word_t tgt_image(input tgt_t t);
        word_t w;
        w = '0;
        w[IOW_TGT_W-1:0] = t;
        return w;
    endfunction

    function automatic logic covers(input win_cfg_t c, input gran_t g);
        return c.en && (g >= c.lo) && (g <= c.hi);
    endfunction

endpackage

// File: rtl/iow_regfile.sv
module iow_regfile
    import iow_pkg::*;
#(
    parameter int unsigned NUM_WIN = 16,
    localparam int unsigned REG_AW = $clog2((NUM_WIN + 1) * 16),
    localparam int unsigned IDX_W  = REG_AW - IOW_STRIDE_B
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_we,
    input  logic [REG_AW-1:0]          reg_addr,
    input  word_t                      reg_wdata,
    output word_t                      reg_rdata,
    output win_cfg_t [NUM_WIN-1:0]     cfg_o,
    output tgt_t                       dflt_o
);

    win_cfg_t [NUM_WIN-1:0] cfg_q;
    tgt_t                   dflt_q;

    logic [IDX_W-1:0] idx;
    logic [3:0]       sub;
    reg_kind_e        kind;
    win_cfg_t         sel_cfg;

    assign idx = reg_addr[REG_AW-1:IOW_STRIDE_B];
    assign sub = reg_addr[IOW_STRIDE_B-1:0];

    // Offset decode: window slots below NUM_WIN, default slot at NUM_WIN.
    always_comb begin
        kind = RK_NONE;
        if (idx < IDX_W'(NUM_WIN)) begin
            case (sub)
                4'h0:    kind = RK_START;
                4'h8:    kind = RK_END;
                4'hC:    kind = RK_TGT;
                default: kind = RK_NONE;
            endcase
        end else if (idx == IDX_W'(NUM_WIN) && sub == 4'h0) begin
            kind = RK_DFLT;
        end
    end

    always_comb begin
        sel_cfg = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (idx == IDX_W'(w)) sel_cfg = cfg_q[w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            dflt_q <= '0;
        end else if (reg_we) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (idx == IDX_W'(w)) begin
                    case (kind)
                        RK_START: begin
                            cfg_q[w].en <= reg_wdata[0];
                            cfg_q[w].lo <= reg_wdata[IOW_DATA_W-1:IOW_FIELD_LSB];
                        end
                        RK_END:  cfg_q[w].hi  <= reg_wdata[IOW_DATA_W-1:IOW_FIELD_LSB];
                        RK_TGT:  cfg_q[w].tgt <= reg_wdata[IOW_TGT_W-1:0];
                        default: ;
                    endcase
                end
            end
            if (kind == RK_DFLT) dflt_q <= reg_wdata[IOW_TGT_W-1:0];
        end
    end

    always_comb begin
        case (kind)
            RK_START: reg_rdata = start_image(sel_cfg);
            RK_END:   reg_rdata = end_image(sel_cfg);
            RK_TGT:   reg_rdata = tgt_image(sel_cfg.tgt);
            RK_DFLT:  reg_rdata = tgt_image(dflt_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign cfg_o  = cfg_q;
    assign dflt_o = dflt_q;

    // R8: writes to unmapped offsets leave every register untouched
    p_unmapped_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && kind == RK_NONE) |=> ($stable(cfg_q) && $stable(dflt_q)));

    // R9: reset clears all windows and the default target
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (cfg_q == '0 && dflt_q == '0));

endmodule

// File: rtl/iow_match.sv
module iow_match
    import iow_pkg::*;
#(
    parameter int unsigned NUM_WIN = 16
) (
    input  win_cfg_t [NUM_WIN-1:0] cfg_i,
    input  tgt_t                   dflt_i,
    input  gran_t                  gran_i,
    output lookup_t                result_o
);

    logic [NUM_WIN-1:0] hit_vec;
    logic [NUM_WIN-1:0] en_vec;
    logic [NUM_WIN-1:0] grant;
    tgt_t               win_tgt;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign hit_vec[w] = covers(cfg_i[w], gran_i);
        assign en_vec[w]  = cfg_i[w].en;
    end

    // Lowest index wins.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (hit_vec[w] && !found) begin
                grant[w] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        win_tgt = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            win_tgt = win_tgt | ({IOW_TGT_W{grant[w]}} & cfg_i[w].tgt);
        end
    end

    assign result_o.hit = |grant;
    assign result_o.tgt = (|grant) ? win_tgt : dflt_i;

    always_comb begin
        // R7: at most one window is selected
        p_grant_onehot_r7: assert ($onehot0(grant));
        // R4: a disabled window is never selected
        p_grant_enabled_r4: assert ((grant & ~en_vec) == '0);
    end

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
    import iow_pkg::*;
#(
    parameter int unsigned NUM_WIN = 16,
    localparam int unsigned REG_AW = $clog2((NUM_WIN + 1) * 16)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_we,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [IOW_DATA_W-1:0]  reg_wdata,
    output logic [IOW_DATA_W-1:0]  reg_rdata,
    input  logic                   lk_valid,
    input  logic [IOW_ADDR_W-1:0]  lk_addr,
    output logic                   lk_out_valid,
    output logic                   lk_hit,
    output logic [IOW_TGT_W-1:0]   lk_target
);

    win_cfg_t [NUM_WIN-1:0] cfg;
    tgt_t                   dflt;
    lookup_t                res_d;
    lookup_t                res_q;
    logic                   vld_q;

    iow_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cfg_o    (cfg),
        .dflt_o   (dflt)
    );

    iow_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg_i   (cfg),
        .dflt_i  (dflt),
        .gran_i  (addr_gran(lk_addr)),
        .result_o(res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= lk_valid;
            if (lk_valid) res_q <= res_d;
        end
    end

    assign lk_out_valid = vld_q;
    assign lk_hit       = res_q.hit;
    assign lk_target    = res_q.tgt;

    // R5: a miss reports the default target in force when the request arrived
    p_miss_default_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_out_valid && !lk_hit) |-> (lk_target == $past(dflt)));

    // R6: every request yields a valid result on the next cycle
    p_result_latency_r6: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_out_valid);

    // R6: results hold while no request is presented
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> ($stable(lk_hit) && $stable(lk_target) && !lk_out_valid));

endmodule

// File: tb/tb_io_window_decoder.sv
module tb_io_window_decoder;
    localparam int unsigned NW = 4;
    localparam int unsigned RAW = $clog2((NW + 1) * 16);
    localparam int unsigned DFLT_OFF = 16 * NW;

    logic            clk = 1'b0;
    logic            rst;
    logic            reg_we;
    logic [RAW-1:0]  reg_addr;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic            lk_valid;
    logic [47:0]     lk_addr;
    logic            lk_out_valid;
    logic            lk_hit;
    logic [7:0]      lk_target;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [27:0] m_lo [NW];
    logic [27:0] m_hi [NW];
    logic        m_en [NW];
    logic [7:0]  m_tgt [NW];
    logic [7:0]  m_dflt;

    always #4 clk = ~clk;

    io_window_decoder #(.NUM_WIN(NW)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .lk_out_valid(lk_out_valid), .lk_hit(lk_hit),
        .lk_target(lk_target)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = RAW'(off); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int off, output logic [31:0] d);
        @(negedge clk);
        reg_addr = RAW'(off);
        #1 d = reg_rdata;
    endtask

    task automatic setwin(input int w, input logic [27:0] lo, input logic [27:0] hi,
                          input logic en, input logic [7:0] t);
        wr(16*w + 0,  {lo, 3'b000, en});
        wr(16*w + 8,  {hi, 4'hF});
        wr(16*w + 12, {24'hABCDEF, t});
        m_lo[w] = lo; m_hi[w] = hi; m_en[w] = en; m_tgt[w] = t;
    endtask

    function automatic logic [8:0] model(input logic [27:0] g);
        for (int w = 0; w < NW; w++) begin
            if (m_en[w] && g >= m_lo[w] && g <= m_hi[w]) return {1'b1, m_tgt[w]};
        end
        return {1'b0, m_dflt};
    endfunction

    function automatic logic [27:0] sweep_gran(input int k);
        if (k < 32) return 28'(k);
        return 28'hFFFFFFE + 28'(k - 32);
    endfunction

    // Back-to-back sweep: a new address each cycle, result checked one cycle later.
    task automatic sweep(input string tag);
        logic [8:0] exp;
        logic [27:0] g;
        for (int k = 0; k <= 34; k++) begin
            @(negedge clk);
            if (k > 0) begin
                g = sweep_gran(k - 1);
                exp = model(g);
                chk({tag, " valid R6"}, lk_out_valid, 1'b1);
                chk({tag, " hit R3"}, lk_hit, exp[8]);
                chk({tag, " target R3"}, lk_target, exp[7:0]);
            end
            if (k < 34) begin
                lk_valid = 1'b1;
                lk_addr = {sweep_gran(k), 20'((k * 40503) & 20'hFFFFF)};
            end else begin
                lk_valid = 1'b0;
            end
        end
    endtask

    task automatic look(input logic [47:0] a, input string tag, input logic h, input logic [7:0] t);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({tag, " valid"}, lk_out_valid, 1'b1);
        chk({tag, " hit"}, lk_hit, h);
        chk({tag, " target"}, lk_target, t);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        lk_valid = 1'b0; lk_addr = '0;
        for (int w = 0; w < NW; w++) begin
            m_lo[w] = '0; m_hi[w] = '0; m_en[w] = 1'b0; m_tgt[w] = '0;
        end
        m_dflt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        for (int off = 0; off <= DFLT_OFF; off += 4) begin
            rd(off, d);
            chk("R9 reset readback", d, 32'h0);
        end
        chk("R9 reset out_valid", lk_out_valid, 1'b0);
        look(48'h0, "R9 reset lookup", 1'b0, 8'h00);

        // R2 field formats, R1 offsets
        wr(16*1 + 0, 32'hFFFF_FFFF);
        rd(16*1 + 0, d); chk("R2 start image", d, 32'hFFFF_FFF1);
        wr(16*1 + 8, 32'hFFFF_FFFF);
        rd(16*1 + 8, d); chk("R2 end image", d, 32'hFFFF_FFF0);
        wr(16*1 + 12, 32'h1234_56A5);
        rd(16*1 + 12, d); chk("R2 target image", d, 32'h0000_00A5);
        rd(16*2 + 0, d); chk("R1 neighbour start untouched", d, 32'h0);
        wr(DFLT_OFF, 32'hFFFF_FF5A); m_dflt = 8'h5A;
        rd(DFLT_OFF, d); chk("R1 default offset R2", d, 32'h0000_005A);
        m_lo[1] = 28'hFFFFFFF; m_hi[1] = 28'hFFFFFFF; m_en[1] = 1'b1; m_tgt[1] = 8'hA5;
        look(48'hFFFF_FFFF_FFFF, "R3 top granule", 1'b1, 8'hA5);
        look(48'hFFFF_FFEF_FFFF, "R5 below top granule", 1'b0, 8'h5A);

        // R8 unmapped offsets: read zero, writes ignored
        wr(16*1 + 4, 32'hFFFF_FFFF);
        rd(16*1 + 4, d); chk("R8 hole read", d, 32'h0);
        wr(DFLT_OFF + 4, 32'h0000_0033);
        rd(DFLT_OFF + 4, d); chk("R8 past default read", d, 32'h0);
        wr(DFLT_OFF + 16, 32'h0000_0033);
        rd(DFLT_OFF, d); chk("R8 default unchanged", d, 32'h0000_005A);
        rd(16*1 + 0, d); chk("R8 start unchanged", d, 32'hFFFF_FFF1);
        look(48'h0000_0010_0000, "R8 lookup unchanged", 1'b0, 8'h5A);

        // Window set: overlap 0/1, disabled 2, single granule 3
        setwin(0, 28'd2,  28'd5,  1'b1, 8'h11);
        setwin(1, 28'd4,  28'd9,  1'b1, 8'h22);
        setwin(2, 28'd10, 28'd12, 1'b0, 8'h33);
        setwin(3, 28'd20, 28'd20, 1'b1, 8'h44);
        sweep("R7 overlap sweep");
        look(48'h0000_0040_0000, "R7 overlap lowest wins", 1'b1, 8'h11);
        look(48'h0000_00B0_0000, "R4 disabled window miss", 1'b0, 8'h5A);

        // R4 disable window 0, start stays readable
        wr(0, {28'd2, 4'h0}); m_en[0] = 1'b0;
        rd(0, d); chk("R4 start kept after disable", d, {28'd2, 4'h0});
        sweep("R4 after disable");
        look(48'h0000_0040_0000, "R4 window1 takes over", 1'b1, 8'h22);

        // Enable window 2, R10 inverted window 3
        setwin(2, 28'd10, 28'd12, 1'b1, 8'h33);
        setwin(3, 28'd25, 28'd21, 1'b1, 8'h44);
        m_dflt = 8'hC3; wr(DFLT_OFF, 32'h0000_00C3);
        sweep("R10 inverted window");
        look(48'h0000_0170_0000, "R10 inverted miss", 1'b0, 8'hC3);

        // R3 low bits ignored at both bounds
        look(48'h0000_00A0_0000, "R3 start bound", 1'b1, 8'h33);
        look(48'h0000_00CF_FFFF, "R3 end bound inclusive", 1'b1, 8'h33);
        look(48'h0000_00D0_0000, "R3 past end", 1'b0, 8'hC3);

        // R6 hold when no request
        look(48'h0000_00A1_2345, "R6 setup", 1'b1, 8'h33);
        @(negedge clk);
        lk_addr = 48'h0000_0000_0000;
        @(negedge clk);
        chk("R6 out_valid low", lk_out_valid, 1'b0);
        chk("R6 hit held", lk_hit, 1'b1);
        chk("R6 target held", lk_target, 8'h33);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule